// File: doc/BRIEF.md
# Backup-Boot Timeout Timer

This block counts whole seconds after the system has started from a backup boot device. A prescaler divides the input clock, whose frequency is a parameter, into a one-cycle tick each second. A seconds counter advances on each tick. When the elapsed count reaches a limit that software programs, the block latches a sticky disable flag. Other logic uses that flag to switch off the alternate firmware hub.

Software reads the limit back and can rewrite it. Each rewrite restarts the count. Software clears the flag by writing one to its status bit, which also starts a fresh count. When the backup device is itself the primary boot source, the flag is held at one.

The control is a three-state machine:
- `ST_COUNT`: seconds are being counted; the flag is low.
- `ST_EXPIRED`: the limit was reached; the flag is high and the count is frozen.
- `ST_PRIMARY`: primary-boot mode; the flag is forced high.

The transitions are:
- `T_EXPIRE`: `ST_COUNT` to `ST_EXPIRED` on a tick that reaches the limit.
- `T_CLEAR`: `ST_EXPIRED` to `ST_COUNT` on a write-one-to-clear.
- `T_RESTART`: `ST_COUNT` to `ST_COUNT` on a limit write or a clear write.
- `T_ENTER_PRI`: any state to `ST_PRIMARY` while primary mode is asserted.
- `T_LEAVE_PRI`: `ST_PRIMARY` to `ST_COUNT` when primary mode drops.

Top module: `boot_fallback_timer`

## Requirements
- R1: After reset, `limit_q` reads 4, `status_q` reads 0 and `hub_disable` is 0.
- R2: With limit N (1 to 255), the flag rises exactly N*TICK_CYCLES clock edges after the edge that restarted the count, where TICK_CYCLES is the prescaler period in clocks (the parameter `CLK_HZ`). A restart is reset release, a limit write, a clear write or leaving primary mode.
- R3: A limit of 0 makes the flag rise on the first tick, TICK_CYCLES edges after the restart.
- R4: Once set in backup mode, the flag stays at 1 and counting stops until a clear write or primary mode changes it.
- R5: A write with `cfg_sel`=1 and `cfg_wdata[6]`=1 clears the flag at the next edge and restarts the count. A write with `cfg_sel`=1 and `cfg_wdata[6]`=0 leaves the flag unchanged.
- R6: A write with `cfg_sel`=0 loads `cfg_wdata` into the limit, which `limit_q` shows from the next cycle. The same write restarts the seconds count from zero.
- R7: While `primary_mode` is 1, the flag reads 1 from the next cycle on, and clear writes do not lower it. When `primary_mode` returns to 0, the flag drops and the count restarts.
- R8: `hub_disable` always equals `status_q[6]`. All other bits of `status_q` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| primary_mode | input | 1 | 1 when the backup device is the primary boot source |
| cfg_wr | input | 1 | Register write strobe, one cycle |
| cfg_sel | input | 1 | 0 selects the limit register, 1 selects the status register |
| cfg_wdata | input | 8 | Write data; bit 6 is the clear bit in status writes |
| limit_q | output | 8 | Current timeout limit in seconds |
| status_q | output | 8 | Status; bit 6 is the disable flag |
| hub_disable | output | 1 | Disable output to the firmware hub logic |

## Verification
The assertions check on every cycle that the output and the status bit agree, and that the flag holds while no clear write or mode change occurs. They also check that the flag only rises after a second tick or in primary mode, that a clear write lowers it, that a limit write is read back, and that primary mode holds the flag high. Only the bench's scenarios can show the exact expiry time for each limit value (0, the default, mid-count rewrites, and 255), the restart after clears and mode exits, and that a status write with bit 6 low does nothing.

// File: rtl/boot_fallback_pkg.sv
package boot_fallback_pkg;
    typedef enum logic [1:0] {
        ST_COUNT   = 2'd0,
        ST_EXPIRED = 2'd1,
        ST_PRIMARY = 2'd2
    } fb_state_e;

    localparam int REG_W      = 8;
    localparam int FLAG_BIT   = 6;
    localparam int SEL_LIMIT  = 0;
    localparam int SEL_STATUS = 1;
endpackage

// File: rtl/bft_prescaler.sv
module bft_prescaler #(
    parameter int CLK_HZ = 33_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

    logic [CW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (hold || pcnt == LAST) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign tick = !hold && (pcnt == LAST);
endmodule

// File: rtl/bft_regs.sv
module bft_regs
    import boot_fallback_pkg::*;
#(
    parameter int W         = REG_W,
    parameter int DEF_LIMIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic         cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    input  logic         flag,
    output logic [W-1:0] limit_q,
    output logic [W-1:0] status_q,
    output logic         load_limit,
    output logic         clear_req
);
    assign load_limit = cfg_wr && (cfg_sel == 1'(SEL_LIMIT));
    assign clear_req  = cfg_wr && (cfg_sel == 1'(SEL_STATUS)) && cfg_wdata[FLAG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= W'(DEF_LIMIT);
        end else if (load_limit) begin
            limit_q <= cfg_wdata;
        end
    end

    always_comb begin
        status_q           = '0;
        status_q[FLAG_BIT] = flag;
    end
endmodule

// File: rtl/bft_fsm.sv
module bft_fsm
    import boot_fallback_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         primary_mode,
    input  logic         sec_tick,
    input  logic         restart,
    input  logic         clear_req,
    input  logic [W-1:0] limit,
    output logic         flag,
    output logic         counting
);
    fb_state_e    state, state_nx;
    logic [W-1:0] secs;
    logic         reach;

    assign reach = ({1'b0, secs} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COUNT: begin
                if (primary_mode)           state_nx = ST_PRIMARY;
                else if (restart)           state_nx = ST_COUNT;
                else if (sec_tick && reach) state_nx = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (primary_mode)           state_nx = ST_PRIMARY;
                else if (clear_req)         state_nx = ST_COUNT;
            end
            ST_PRIMARY: begin
                if (!primary_mode)          state_nx = ST_COUNT;
            end
            default:                        state_nx = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secs <= '0;
        end else if (state != ST_COUNT || restart) begin
            secs <= '0;
        end else if (sec_tick) begin
            secs <= secs + 1'b1;
        end
    end

    always_comb begin
        flag     = (state != ST_COUNT);
        counting = (state == ST_COUNT);
    end
endmodule

// File: rtl/boot_fallback_timer.sv
module boot_fallback_timer
    import boot_fallback_pkg::*;
#(
    parameter int CLK_HZ    = 33_000_000,
    parameter int DEF_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       primary_mode,
    input  logic       cfg_wr,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] limit_q,
    output logic [7:0] status_q,
    output logic       hub_disable
);
    logic sec_tick, load_limit, clear_req, flag, counting, restart;

    assign restart = load_limit || clear_req;

    bft_regs #(.W(REG_W), .DEF_LIMIT(DEF_LIMIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .flag(flag), .limit_q(limit_q),
        .status_q(status_q), .load_limit(load_limit), .clear_req(clear_req)
    );

    bft_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk(clk), .rst_n(rst_n), .hold(restart || !counting), .tick(sec_tick)
    );

    bft_fsm #(.W(REG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .primary_mode(primary_mode),
        .sec_tick(sec_tick), .restart(restart), .clear_req(clear_req),
        .limit(limit_q), .flag(flag), .counting(counting)
    );

    assign hub_disable = flag;
endmodule

// File: rtl/bft_checker.sv
module bft_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       primary_mode,
    input logic       cfg_wr,
    input logic       cfg_sel,
    input logic [7:0] cfg_wdata,
    input logic [7:0] limit_q,
    input logic [7:0] status_q,
    input logic       hub_disable,
    input logic       sec_tick
);
    logic armed;
    logic clr_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign clr_wr = cfg_wr && cfg_sel && cfg_wdata[6];

    p_out_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_disable == status_q[6]) && ((status_q & 8'hBF) == 8'h00));

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && hub_disable && !primary_mode && !$past(primary_mode) && !clr_wr
        |=> hub_disable);

    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !hub_disable && !primary_mode && !sec_tick |=> !hub_disable);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && clr_wr && !primary_mode |=> !hub_disable);

    p_limit_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cfg_wr && !cfg_sel |=> limit_q == $past(cfg_wdata));

    p_primary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && primary_mode |=> hub_disable);
endmodule

bind boot_fallback_timer bft_checker u_chk (
    .clk(clk), .rst_n(rst_n), .primary_mode(primary_mode), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .limit_q(limit_q),
    .status_q(status_q), .hub_disable(hub_disable), .sec_tick(sec_tick)
);

// File: tb/tb_boot_fallback_timer.sv
module tb_boot_fallback_timer;
    localparam int P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       primary_mode = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] limit_q, status_q;
    logic       hub_disable;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    int  restart_cyc = 0;
    bit  watch = 1'b0;
    bit  prev_hub = 1'b0;
    bit  done = 1'b0;
    int  exp_q[$];

    always #2 clk = ~clk;

    boot_fallback_timer #(.CLK_HZ(P)) dut (
        .clk(clk), .rst_n(rst_n), .primary_mode(primary_mode), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .limit_q(limit_q),
        .status_q(status_q), .hub_disable(hub_disable)
    );

    always @(posedge clk) cyc++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the expected expiry time when the flag rises
    always @(negedge clk) begin
        if (rst_n && watch && hub_disable && !prev_hub) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected rise", cyc - restart_cyc, -1);
            end else begin
                check("R2/R3 expiry time", cyc - restart_cyc, exp_q.pop_front());
                check("R8 status bit", int'(status_q[6]), 1);
            end
        end
        prev_hub = hub_disable;
    end

    task automatic write_reg(input bit sel, input logic [7:0] data,
                             input bit push, input int exp);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #1;
        if (push) begin
            restart_cyc = cyc;
            exp_q.push_back(exp);
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_rise(input string req);
        int n = 0;
        while (!hub_disable && n < 4000) begin
            @(negedge clk); n++;
        end
        check(req, int'(hub_disable), 1);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 limit reset", int'(limit_q), 4);
        check("R1 status reset", int'(status_q), 0);
        check("R1 hub reset", int'(hub_disable), 0);
        rst_n = 1'b1;
        restart_cyc = cyc;
        exp_q.push_back(4 * P);
        watch = 1'b1;
        wait_rise("R2 default expiry");

        repeat (30) @(negedge clk);
        check("R4 sticky", int'(hub_disable), 1);

        write_reg(1'b1, 8'hBF, 1'b0, 0);
        repeat (2) @(negedge clk);
        check("R5 bit6=0 no effect", int'(hub_disable), 1);

        write_reg(1'b1, 8'h40, 1'b1, 4 * P);
        check("R5 cleared", int'(hub_disable), 0);
        check("R8 cleared status", int'(status_q), 0);
        wait_rise("R5 re-expiry");

        write_reg(1'b0, 8'd7, 1'b0, 0);
        check("R6 readback", int'(limit_q), 7);
        write_reg(1'b1, 8'h40, 1'b1, 7 * P);
        wait_rise("R6 limit 7");

        write_reg(1'b1, 8'h40, 1'b0, 0);
        write_reg(1'b0, 8'd2, 1'b0, 0);
        repeat (15) @(negedge clk);
        write_reg(1'b0, 8'd3, 1'b1, 3 * P);
        wait_rise("R6 rewrite restarts");

        write_reg(1'b0, 8'd0, 1'b0, 0);
        write_reg(1'b1, 8'h40, 1'b1, P);
        wait_rise("R3 zero limit");

        watch = 1'b0;
        write_reg(1'b0, 8'd2, 1'b0, 0);
        write_reg(1'b1, 8'h40, 1'b0, 0);
        @(negedge clk);
        primary_mode = 1'b1;
        @(negedge clk);
        check("R7 forced", int'(hub_disable), 1);
        check("R8 forced status", int'(status_q), 8'h40);
        write_reg(1'b1, 8'h40, 1'b0, 0);
        @(negedge clk);
        check("R7 clear ignored", int'(hub_disable), 1);
        primary_mode = 1'b0;
        @(posedge clk); #1;
        restart_cyc = cyc;
        exp_q.push_back(2 * P);
        @(negedge clk);
        check("R7 released", int'(hub_disable), 0);
        prev_hub = 1'b0;
        watch = 1'b1;
        wait_rise("R7 restart after release");

        write_reg(1'b0, 8'd255, 1'b0, 0);
        write_reg(1'b1, 8'h40, 1'b1, 255 * P);
        wait_rise("R2 limit 255");

        check("R2 queue drained", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule